// File: doc/BRIEF.md
# String Word Load Sequencer

This block carries out a load-string-immediate operation over several clock cycles. A single start pulse supplies a destination register index, a base register index, the value of that base register and a 5-bit byte-count field. The sequencer then reads consecutive bytes from a byte-wide memory port, one handshake per byte, and packs them into 32-bit general-purpose registers. It starts at the destination index and moves upward, wrapping from register 31 back to register 0.

Each register value is built up internally. Exactly one write goes out on the register-file port per register, once its fourth byte or the overall last byte has arrived. Bytes that are left over in the final register are cleared to zero. A register whose index equals the base register index is not written unless it is the final register, but its bytes are still read. The surrounding pipeline holds off while `busy_o` is high and continues after the one-cycle `done_o` pulse.

Top module: `strload_seq`

## Requirements
- R1: The first memory request after a start carries address 0 when the base index is 0, and the base register value otherwise.
- R2: The byte count equals the count field, except that a field of 0 means 32 bytes. The number of registers written is the byte count divided by 4, rounded up, less any skipped register.
- R3: Registers are written in ascending index order starting at the destination index, wrapping from 31 to 0. There is exactly one write per register that is not skipped.
- R4: Within a register, the first byte read lands in bits 31:24, the next in bits 23:16, and so on down to bits 7:0.
- R5: When the bytes run out part-way through the final register, its unfilled low-order bytes are written as zero.
- R6: A register whose index equals the base index is not written unless it is the final register. Its bytes are still read, and the address still advances past them.
- R7: The address held on the memory port stays stable, with the request still asserted, until ready is seen. After each accepted byte the address rises by exactly one.
- R8: A start pulse that arrives while `busy_o` is high has no effect on the operation under way.
- R9: `done_o` is high for exactly one cycle, the cycle after the final register write. `busy_o` is high from the cycle after start through the done cycle.
- R10: While reset is held, and right after it, no request, write, busy or done is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| dst_idx_i | input | 5 | First destination register index |
| base_idx_i | input | 5 | Base register index (0 selects a zero address) |
| base_val_i | input | 32 | Current value of the base register |
| cnt_field_i | input | 5 | Byte-count field, 0 meaning 32 |
| mem_addr_o | output | 32 | Byte read address |
| mem_req_o | output | 1 | Read request valid |
| mem_rdy_i | input | 1 | Read accepted; data valid this cycle |
| mem_data_i | input | 8 | Returned byte |
| rf_idx_o | output | 5 | Register-file write index |
| rf_data_o | output | 32 | Register-file write data |
| rf_we_o | output | 1 | Register-file write enable |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The sequencer is run with several kinds of count field:
- A field of 0 distinguishes the 32-byte meaning of zero from an empty transfer.
- Counts of 1, 5 and 13 show that zero fill comes from the count and is not packing of a neighbouring byte.
- A field of 31 starting at register 31 runs through the wrap.

Base indices are placed in several positions:
- Outside the range.
- Inside the range, where the write must be missing.
- On the final register, where the write must be present.
- At 0, which selects the zero address.

Memory bytes are a function of their address, so a wrong address, a wrong byte lane or a doubled byte shows up as wrong data. Ready is driven either constantly high or in a pseudo-random stall pattern, to separate handshake timing from data order. A second start during a run must leave the expected write sequence unchanged.

// File: rtl/strload_pkg.sv
// Shared constants and the controller state type for the string load sequencer.
package strload_pkg;
    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 5;
    localparam int CNT_W  = 5;
    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LAST = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/strload_addr.sv
// Address and byte-count tracker.
// Loads the start address and byte total on load_i. On each accepted byte
// (take_i) it advances the address by one and lowers the remaining count.
// Assumes take_i is never asserted while the remaining count is zero.
module strload_addr #(
    parameter int ADDR_W = strload_pkg::ADDR_W,
    parameter int CNT_W  = strload_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic [CNT_W:0]    nbytes_i,
    input  logic              take_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_byte_o
);
    logic [CNT_W:0] rem_q;

    // Address register and remaining-byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            rem_q  <= '0;
        end else if (load_i) begin
            addr_o <= ea_i;
            rem_q  <= nbytes_i;
        end else if (take_i) begin
            addr_o <= addr_o + ADDR_W'(1);
            rem_q  <= rem_q - (CNT_W+1)'(1);
        end
    end

    // The byte now on the port is the last of the string.
    assign last_byte_o = (rem_q == (CNT_W+1)'(1));

    // R2
    counter_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> rem_q != '0);
endmodule

// File: rtl/strload_pack.sv
// Byte packer and register-file write generator.
// Builds each register most-significant byte first. It writes the register
// after its last lane or after the string's last byte, leaving the unfilled
// lanes zero. It walks register indices upward modulo 2**IDX_W and drops the
// write for a base-index register that is not the final one.
// Assumes load_i and take_i are never asserted together.
module strload_pack #(
    parameter int REG_W  = strload_pkg::REG_W,
    parameter int BYTE_W = strload_pkg::BYTE_W,
    parameter int IDX_W  = strload_pkg::IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [IDX_W-1:0]  dst_i,
    input  logic [IDX_W-1:0]  base_i,
    input  logic [IDX_W-1:0]  final_i,
    input  logic              take_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              last_byte_i,
    output logic              we_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [REG_W-1:0]  data_o
);
    localparam int BPR   = REG_W / BYTE_W;
    localparam int POS_W = $clog2(BPR);

    logic [REG_W-1:0] acc_q;
    logic [POS_W-1:0] pos_q;
    logic [IDX_W-1:0] cur_q, base_q, final_q;
    logic [REG_W-1:0] merged;
    logic             reg_end;

    // Place the incoming byte in the lane chosen by the byte position.
    always_comb begin
        merged  = acc_q | ({{(REG_W-BYTE_W){1'b0}}, byte_i}
                           << ((BPR - 1 - int'(pos_q)) * BYTE_W));
        reg_end = (pos_q == POS_W'(BPR - 1)) || last_byte_i;
    end

    // Accumulator, lane pointer, register walk and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            pos_q   <= '0;
            cur_q   <= '0;
            base_q  <= '0;
            final_q <= '0;
            we_o    <= 1'b0;
            idx_o   <= '0;
            data_o  <= '0;
        end else if (load_i) begin
            acc_q   <= '0;
            pos_q   <= '0;
            cur_q   <= dst_i;
            base_q  <= base_i;
            final_q <= final_i;
            we_o    <= 1'b0;
        end else if (take_i && reg_end) begin
            we_o    <= (cur_q != base_q) || (cur_q == final_q);
            idx_o   <= cur_q;
            data_o  <= merged;
            acc_q   <= '0;
            pos_q   <= '0;
            cur_q   <= cur_q + IDX_W'(1);
        end else begin
            we_o <= 1'b0;
            if (take_i) begin
                acc_q <= merged;
                pos_q <= pos_q + POS_W'(1);
            end
        end
    end

    // R6
    base_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && idx_o == base_q) |-> idx_o == final_q);
endmodule

// File: rtl/strload_seq.sv
// String word load sequencer top.
// Forms the start address and byte count, runs the memory read handshake and
// sequences the operation through run, last-write and done states. Start is
// honoured only when idle. Assumes mem_data_i is valid whenever mem_rdy_i is
// high during a request.
module strload_seq
    import strload_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int RW = REG_W,
    parameter int BW = BYTE_W,
    parameter int IW = IDX_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [IW-1:0] dst_idx_i,
    input  logic [IW-1:0] base_idx_i,
    input  logic [RW-1:0] base_val_i,
    input  logic [CW-1:0] cnt_field_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_req_o,
    input  logic          mem_rdy_i,
    input  logic [BW-1:0] mem_data_i,
    output logic [IW-1:0] rf_idx_o,
    output logic [RW-1:0] rf_data_o,
    output logic          rf_we_o,
    output logic          busy_o,
    output logic          done_o
);
    localparam int BPR   = RW / BW;
    localparam int POS_W = $clog2(BPR);

    seq_state_t    state_q;
    logic          load, take, last_byte;
    logic [AW-1:0] ea_c;
    logic [CW:0]   nbytes_c;
    logic [IW-1:0] nregs_c, final_c;

    // Operand decode: address, byte total and final register index.
    always_comb begin
        ea_c     = (base_idx_i == '0) ? '0 : AW'(base_val_i);
        nbytes_c = (cnt_field_i == '0) ? (CW+1)'(1 << CW) : {1'b0, cnt_field_i};
        nregs_c  = IW'((nbytes_c + (CW+1)'(BPR - 1)) >> POS_W);
        final_c  = dst_idx_i + nregs_c - IW'(1);
    end

    assign load      = (state_q == ST_IDLE) && start_i;
    assign mem_req_o = (state_q == ST_RUN);
    assign take      = mem_req_o && mem_rdy_i;
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = (state_q == ST_DONE);

    // Operation sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) state_q <= ST_RUN;
                ST_RUN:  if (take && last_byte) state_q <= ST_LAST;
                ST_LAST: state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    strload_addr #(.ADDR_W(AW), .CNT_W(CW)) addr_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .ea_i(ea_c),
        .nbytes_i(nbytes_c), .take_i(take), .addr_o(mem_addr_o),
        .last_byte_o(last_byte)
    );

    strload_pack #(.REG_W(RW), .BYTE_W(BW), .IDX_W(IW)) pack_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .dst_i(dst_idx_i),
        .base_i(base_idx_i), .final_i(final_c), .take_i(take),
        .byte_i(mem_data_i), .last_byte_i(last_byte), .we_o(rf_we_o),
        .idx_o(rf_idx_o), .data_o(rf_data_o)
    );

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)));
    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_rdy_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + AW'(1)));
    // R9
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(rf_we_o));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/strload_seq_tb.sv
`timescale 1ns/1ps
module strload_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  dst_idx_i = '0, base_idx_i = '0, cnt_field_i = '0;
    logic [31:0] base_val_i = '0;
    logic [31:0] mem_addr_o;
    logic        mem_req_o;
    logic        mem_rdy_i = 1'b1;
    logic [7:0]  mem_data_i;
    logic [4:0]  rf_idx_o;
    logic [31:0] rf_data_o;
    logic        rf_we_o, busy_o, done_o;

    int checks = 0;
    int fails  = 0;
    logic [4:0]  exp_idx[$];
    logic [31:0] exp_data[$];
    bit          stall_mode = 1'b0;
    logic [7:0]  lfsr = 8'hA5;

    always #2.5 clk = ~clk;

    strload_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dst_idx_i(dst_idx_i),
        .base_idx_i(base_idx_i), .base_val_i(base_val_i), .cnt_field_i(cnt_field_i),
        .mem_addr_o(mem_addr_o), .mem_req_o(mem_req_o), .mem_rdy_i(mem_rdy_i),
        .mem_data_i(mem_data_i), .rf_idx_o(rf_idx_o), .rf_data_o(rf_data_o),
        .rf_we_o(rf_we_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [7:0] mem_at(input logic [31:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
    endfunction

    always_comb mem_data_i = mem_at(mem_addr_o);

    // Ready pattern: constant or pseudo-random stalls.
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_rdy_i = stall_mode ? lfsr[0] : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compare every register write against the scoreboard (R3 R4 R5 R6).
    always @(negedge clk) begin
        if (rst_n && rf_we_o) begin
            if (exp_idx.size() == 0) begin
                chk(1'b0, "R3 unexpected write", {27'd0, rf_idx_o}, 32'hFFFF_FFFF);
            end else begin
                logic [4:0]  ei;
                logic [31:0] ed;
                ei = exp_idx.pop_front();
                ed = exp_data.pop_front();
                chk(rf_idx_o == ei, "R3 write index", {27'd0, rf_idx_o}, {27'd0, ei});
                chk(rf_data_o == ed, "R4 R5 write data", rf_data_o, ed);
            end
        end
    end

    // Driver: push expected writes and launch one operation.
    task automatic run_op(input logic [4:0] dst, input logic [4:0] base, input logic [31:0] bval,
                          input logic [4:0] field, input bit stall, input bit second_start);
        logic [31:0] ea;
        int n, nr;
        logic [4:0] fin;
        ea  = (base == 5'd0) ? 32'd0 : bval;
        n   = (field == 5'd0) ? 32 : int'(field);
        nr  = (n + 3) / 4;
        fin = 5'(int'(dst) + nr - 1);
        for (int r = 0; r < nr; r++) begin
            logic [4:0]  idx;
            logic [31:0] d;
            idx = 5'(int'(dst) + r);
            d = '0;
            for (int b = 0; b < 4; b++)
                if (r*4 + b < n) d |= {24'd0, mem_at(ea + 32'(r*4 + b))} << (24 - 8*b);
            if (idx != base || idx == fin) begin
                exp_idx.push_back(idx);
                exp_data.push_back(d);
            end
        end
        stall_mode = stall;
        @(negedge clk);
        dst_idx_i = dst; base_idx_i = base; base_val_i = bval; cnt_field_i = field;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && mem_req_o, "R9 busy after start", {31'd0, busy_o}, 32'd1);
        chk(mem_addr_o == ea, "R1 first address", mem_addr_o, ea);
        if (second_start) begin
            repeat (3) @(negedge clk);
            // R8: a start while busy must not disturb the run.
            dst_idx_i = dst + 5'd7; base_idx_i = 5'd2; base_val_i = 32'h0000_9000; cnt_field_i = 5'd3;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o == 1'b1, "R8 still busy", {31'd0, busy_o}, 32'd1);
        end
        while (!done_o) @(negedge clk);
        chk(exp_idx.size() == 0, "R2 write count", 32'(exp_idx.size()), 32'd0);
        @(negedge clk);
        chk(!done_o && !busy_o, "R9 done pulse", {30'd0, done_o, busy_o}, 32'd0);
        exp_idx.delete();
        exp_data.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet while reset is held.
        chk(!mem_req_o && !rf_we_o && !busy_o && !done_o, "R10 in reset",
            {28'd0, mem_req_o, rf_we_o, busy_o, done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_o && !rf_we_o && !busy_o && !done_o, "R10 after reset",
            {28'd0, mem_req_o, rf_we_o, busy_o, done_o}, 32'd0);

        run_op(5'd3,  5'd0,  32'hDEAD_BEEF, 5'd8,  1'b0, 1'b0); // R1 base 0 -> address 0
        run_op(5'd5,  5'd1,  32'h0000_0100, 5'd0,  1'b0, 1'b0); // R2 field 0 = 32 bytes
        run_op(5'd3,  5'd20, 32'h0000_1234, 5'd5,  1'b1, 1'b0); // R5 partial final
        run_op(5'd30, 5'd9,  32'h0000_2001, 5'd13, 1'b1, 1'b0); // R3 wrap 31 -> 0
        run_op(5'd10, 5'd11, 32'h0000_3000, 5'd12, 1'b0, 1'b0); // R6 skip inside range
        run_op(5'd10, 5'd12, 32'h0000_3100, 5'd10, 1'b1, 1'b0); // R6 base is final
        run_op(5'd31, 5'd4,  32'h0000_40FE, 5'd31, 1'b1, 1'b1); // R8 R7 long wrap with stalls
        run_op(5'd7,  5'd7,  32'h0000_5000, 5'd1,  1'b0, 1'b0); // R5 single byte, base is final
        run_op(5'd0,  5'd0,  32'h0000_0000, 5'd6,  1'b1, 1'b0); // R6 base 0 inside range

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule